// File: doc/BRIEF.md
# Snapshot Monitoring Register Bank

This block is a small read-only status register file that sits behind a host control interface. It runs two payload byte counters that never stop. One counts bytes forwarded toward the attached device and the other counts bytes taken in from it. Each counter advances on a single-cycle increment pulse. The block also presents live level inputs that describe stream connections and elastic buffer fill state.

The host reads the block one byte at a time. It drives a strobe and an 8-bit address, and the byte comes back on a registered data output. A 32-bit counter spans four byte addresses, so the host could otherwise see a torn value while the counter moves between reads. To prevent this, a read of address 0 freezes every counter and status bit into a snapshot. All counter addresses then return that frozen copy until address 0 is read again. The host therefore reads address 0 first, then the counter bytes in any order.

Top module: `stat_snap_regs`

## Requirements
- R1: After synchronous reset both live counters, the whole snapshot and `rd_data` are zero.
- R2: `rd_data` is updated only on a rising clock edge at which `rd_stb` is high, and it then holds its value until the next strobed edge.
- R3: A read of address 0 returns the status byte as it is at that edge: bits 2:0 are `link_up[2:0]` (1 = connected), bits 4:3 are `tx_empty[1:0]` (1 = transmit buffer empty), bits 6:5 are `rx_high[1:0]` (1 = receive buffer above three-quarters), and bit 7 is 0.
- R4: A read of address 0 copies the status and both live counters into the snapshot at the same edge. Addresses 1 to 8 return snapshot contents only, so later increments and status changes are not visible there until address 0 is read again.
- R5: Addresses 1, 2, 3 and 4 return bytes 0 (least significant), 1, 2 and 3 of the snapshotted forward counter. Bits above the counter width read as 0.
- R6: Addresses 5, 6, 7 and 8 return bytes 0 (least significant), 1, 2 and 3 of the snapshotted receive counter. Bits above the counter width read as 0.
- R7: Each live counter adds one on every clock edge where its increment input is high. Once it reaches its all-ones value, it wraps to zero.
- R8: An increment that coincides with an address-0 read is kept in the live counter. The snapshot taken at that edge holds the count from before that increment.
- R9: Reads of addresses 9 to 255 return 0x00 and leave the snapshot unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Read strobe, one cycle per byte read |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 8 | Registered read data |
| link_up | input | 3 | Connection state: stream 1, stream 2, control port |
| tx_empty | input | 2 | Transmit elastic buffer empty, streams 1 and 2 |
| rx_high | input | 2 | Receive elastic buffer above three-quarters, streams 1 and 2 |
| fwd_inc | input | 1 | One byte forwarded toward the device |
| rcv_inc | input | 1 | One byte received from the device |

## Verification
The bench instantiates the block with a 12-bit counter width instead of the 32-bit default. This lets it drive a counter to its all-ones value and across the wrap within a few thousand pulses. With that width, bytes 1 and up of each counter carry zero-extension bits, so the bench also checks that the upper counter bytes stay at zero. The byte ordering, the snapshot freeze, the coincident increment and the wrap are each reached with small, exactly predicted pulse counts.

// File: rtl/mon_pkg.sv
package mon_pkg;

    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 8;
    localparam int MAP_CNT_W   = 32;
    localparam int CNT_BYTES   = MAP_CNT_W / DATA_W;
    localparam int N_CNT       = 2;

    localparam logic [ADDR_W-1:0] A_STAT     = 8'd0;
    localparam logic [ADDR_W-1:0] A_FWD_BASE = 8'd1;
    localparam logic [ADDR_W-1:0] A_RCV_BASE = 8'd5;
    localparam logic [ADDR_W-1:0] A_LAST     = A_RCV_BASE + ADDR_W'(CNT_BYTES - 1);

    typedef enum logic [0:0] {
        CNT_FWD = 1'b0,
        CNT_RCV = 1'b1
    } cnt_sel_e;

    typedef struct packed {
        logic [1:0] rx_high;
        logic [1:0] tx_empty;
        logic [2:0] link_up;
    } stat_t;

    typedef struct packed {
        stat_t                stat;
        logic [MAP_CNT_W-1:0] fwd;
        logic [MAP_CNT_W-1:0] rcv;
    } snap_t;

    function automatic logic [DATA_W-1:0] pick_byte(
        input logic [MAP_CNT_W-1:0] word,
        input logic [ADDR_W-1:0]    idx
    );
        logic [DATA_W-1:0] b;
        b = '0;
        for (int i = 0; i < CNT_BYTES; i++) begin
            if (idx == ADDR_W'(i)) b = word[i*DATA_W +: DATA_W];
        end
        return b;
    endfunction

    function automatic logic [DATA_W-1:0] stat_byte(input stat_t s);
        return {1'b0, s};
    endfunction

endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (inc) cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/snap_latch.sv
module snap_latch
    import mon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap,
    input  snap_t live,
    output snap_t held
);
    always_ff @(posedge clk) begin
        if (rst)      held <= '0;
        else if (cap) held <= live;
    end
endmodule

// File: rtl/reg_readout.sv
module reg_readout
    import mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  stat_t             live_stat,
    input  snap_t             held,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt = '0;
        if (rd_addr == A_STAT) begin
            nxt = stat_byte(live_stat);
        end else if (rd_addr >= A_FWD_BASE && rd_addr < A_RCV_BASE) begin
            nxt = pick_byte(held.fwd, rd_addr - A_FWD_BASE);
        end else if (rd_addr >= A_RCV_BASE && rd_addr <= A_LAST) begin
            nxt = pick_byte(held.rcv, rd_addr - A_RCV_BASE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (rd_stb) rd_data <= nxt;
    end
endmodule

// File: rtl/stat_snap_regs.sv
module stat_snap_regs
    import mon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_stb,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic [2:0] link_up,
    input  logic [1:0] tx_empty,
    input  logic [1:0] rx_high,
    input  logic       fwd_inc,
    input  logic       rcv_inc
);
    localparam int EXT_W = MAP_CNT_W - CNT_W;

    logic [N_CNT-1:0]       inc_vec;
    logic [CNT_W-1:0]       cnt_arr [N_CNT];
    logic [MAP_CNT_W-1:0]   fwd_live;
    logic [MAP_CNT_W-1:0]   rcv_live;
    stat_t                  live_stat;
    snap_t                  live_snap;
    snap_t                  snap_q;
    logic                   cap;

    assign inc_vec[CNT_FWD] = fwd_inc;
    assign inc_vec[CNT_RCV] = rcv_inc;

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        evt_counter #(.W(CNT_W)) cnt_i (
            .clk (clk),
            .rst (rst),
            .inc (inc_vec[g]),
            .cnt (cnt_arr[g])
        );
    end

    if (EXT_W > 0) begin : g_ext
        assign fwd_live = {{EXT_W{1'b0}}, cnt_arr[CNT_FWD]};
        assign rcv_live = {{EXT_W{1'b0}}, cnt_arr[CNT_RCV]};
    end else begin : g_full
        assign fwd_live = cnt_arr[CNT_FWD];
        assign rcv_live = cnt_arr[CNT_RCV];
    end

    assign live_stat.link_up  = link_up;
    assign live_stat.tx_empty = tx_empty;
    assign live_stat.rx_high  = rx_high;

    assign live_snap.stat = live_stat;
    assign live_snap.fwd  = fwd_live;
    assign live_snap.rcv  = rcv_live;

    assign cap = rd_stb && (rd_addr == A_STAT);

    snap_latch snap_i (
        .clk  (clk),
        .rst  (rst),
        .cap  (cap),
        .live (live_snap),
        .held (snap_q)
    );

    reg_readout rd_i (
        .clk       (clk),
        .rst       (rst),
        .rd_stb    (rd_stb),
        .rd_addr   (rd_addr),
        .live_stat (live_stat),
        .held      (snap_q),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/stat_snap_regs_chk.sv
module stat_snap_regs_chk
    import mon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_stb,
    input logic [7:0]           rd_addr,
    input logic [7:0]           rd_data,
    input logic                 fwd_inc,
    input logic                 rcv_inc,
    input logic [MAP_CNT_W-1:0] fwd_live,
    input logic [MAP_CNT_W-1:0] rcv_live,
    input snap_t                snap_q
);
    localparam logic [MAP_CNT_W-1:0] TOP = MAP_CNT_W'((64'd1 << CNT_W) - 64'd1);

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rd_stb)) |-> $stable(rd_data)); // R2

    AST_STAT_MSB_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_stb) && $past(rd_addr) == 8'd0) |-> !rd_data[7]); // R3

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(rd_stb) && $past(rd_addr) == 8'd0)) |-> $stable(snap_q)); // R4

    AST_FWD_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fwd_inc)) |->
        fwd_live == (($past(fwd_live) == TOP) ? '0 : $past(fwd_live) + 1)); // R7

    AST_RCV_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rcv_inc)) |->
        rcv_live == (($past(rcv_live) == TOP) ? '0 : $past(rcv_live) + 1)); // R7

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(fwd_inc) && !$past(rcv_inc)) |->
        ($stable(fwd_live) && $stable(rcv_live))); // R7

    AST_CAP_PRE_INC: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_stb) && $past(rd_addr) == 8'd0) |->
        (snap_q.fwd == $past(fwd_live) && snap_q.rcv == $past(rcv_live))); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_stb) && $past(rd_addr) > 8'd8) |-> rd_data == 8'h00); // R9
endmodule

bind stat_snap_regs stat_snap_regs_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (rd_stb),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .fwd_inc  (fwd_inc),
    .rcv_inc  (rcv_inc),
    .fwd_live (fwd_live),
    .rcv_live (rcv_live),
    .snap_q   (snap_q)
);

// File: tb/stat_snap_regs_tb_top.sv
module stat_snap_regs_tb_top;
    localparam int TCLK  = 10;
    localparam int CW    = 12;
    localparam int CMASK = (1 << CW) - 1;

    // vector: {status[6:0], forward pulses[7:0], receive pulses[7:0]}
    localparam int NV = 6;
    localparam logic [22:0] VEC [NV] = '{
        {7'b0000001, 8'd3,   8'd0},
        {7'b0000110, 8'd0,   8'd5},
        {7'b0011000, 8'd17,  8'd9},
        {7'b1100000, 8'd255, 8'd1},
        {7'b1010101, 8'd1,   8'd200},
        {7'b0101010, 8'd40,  8'd40}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_addr = 8'd0;
    logic [7:0] rd_data;
    logic [2:0] link_up = '0;
    logic [1:0] tx_empty = '0;
    logic [1:0] rx_high = '0;
    logic       fwd_inc = 1'b0;
    logic       rcv_inc = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int fwd_m = 0;
    int rcv_m = 0;
    bit done  = 1'b0;

    always #(TCLK/2) clk = ~clk;

    stat_snap_regs #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
        .link_up(link_up), .tx_empty(tx_empty), .rx_high(rx_high),
        .fwd_inc(fwd_inc), .rcv_inc(rcv_inc)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic set_stat(input logic [6:0] s);
        @(negedge clk);
        {rx_high, tx_empty, link_up} = s;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_stb = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_stb = 1'b0;
        d = rd_data;
    endtask

    task automatic pulses(input int nf, input int nr);
        int n;
        n = (nf > nr) ? nf : nr;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fwd_inc = (i < nf);
            rcv_inc = (i < nr);
        end
        @(negedge clk);
        fwd_inc = 1'b0;
        rcv_inc = 1'b0;
        fwd_m = (fwd_m + nf) & CMASK;
        rcv_m = (rcv_m + nr) & CMASK;
    endtask

    task automatic chk_cnts(input string req, input int fs, input int rs);
        logic [7:0] d;
        for (int b = 0; b < 4; b++) begin
            rd(8'(1 + b), d);
            check({req, " R5 fwd byte"}, d, 8'((fs >> (8*b)) & 255));
            rd(8'(5 + b), d);
            check({req, " R6 rcv byte"}, d, 8'((rs >> (8*b)) & 255));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] held;
        int fs;
        int rs;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check("R1 rd_data after reset", rd_data, 8'h00);
        rd(8'd0, d);
        check("R1 status after reset", d, 8'h00);
        chk_cnts("R1", 0, 0);

        // table walk: R3, R4, R5, R6, R7
        for (int v = 0; v < NV; v++) begin
            set_stat(VEC[v][22:16]);
            pulses(int'(VEC[v][15:8]), int'(VEC[v][7:0]));
            rd(8'd0, d);
            check("R3 status byte", d, {1'b0, VEC[v][22:16]});
            fs = fwd_m;
            rs = rcv_m;
            chk_cnts("R4 R7 snapshot", fs, rs);
            // R4: later changes stay invisible until the next address-0 read
            set_stat(~VEC[v][22:16]);
            pulses(7, 3);
            chk_cnts("R4 frozen", fs, rs);
        end

        // R2: output holds without a strobe
        rd(8'd1, held);
        @(negedge clk);
        rd_addr = 8'd0;
        fwd_inc = 1'b1;
        repeat (4) @(negedge clk);
        fwd_inc = 1'b0;
        fwd_m = (fwd_m + 4) & CMASK;
        check("R2 hold without strobe", rd_data, held);

        // R8: increment coincident with snapshot
        set_stat(7'b0010011);
        fs = fwd_m;
        rs = rcv_m;
        @(negedge clk);
        rd_stb = 1'b1;
        rd_addr = 8'd0;
        fwd_inc = 1'b1;
        rcv_inc = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        fwd_inc = 1'b0;
        rcv_inc = 1'b0;
        check("R8 R3 status at coincident read", rd_data, 8'h13);
        fwd_m = (fwd_m + 1) & CMASK;
        rcv_m = (rcv_m + 1) & CMASK;
        chk_cnts("R8 pre-increment snapshot", fs, rs);
        rd(8'd0, d);
        chk_cnts("R8 increment kept", fwd_m, rcv_m);

        // R9: unmapped addresses read zero and do not touch the snapshot
        set_stat(7'b1111111);
        pulses(2, 2);
        rd(8'd9, d);
        check("R9 addr 9", d, 8'h00);
        rd(8'd128, d);
        check("R9 addr 128", d, 8'h00);
        rd(8'd255, d);
        check("R9 addr 255", d, 8'h00);
        chk_cnts("R9 snapshot untouched", fwd_m - 2, rcv_m - 2);

        // R7: wrap at all ones
        pulses(CMASK - fwd_m, CMASK - rcv_m);
        rd(8'd0, d);
        chk_cnts("R7 all ones", CMASK, CMASK);
        pulses(1, 1);
        rd(8'd0, d);
        chk_cnts("R7 wrap to zero", 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule